// File: doc/BRIEF.md
# Dock Outgoing Path Register

This block keeps the routing path that a dock stamps onto every packet it sends. The path is held in a register of configurable width. A move instruction, decoded upstream, can rewrite it. Each move names one of three sources: a 13-bit immediate field carried in the instruction, a 12-bit slice of the word arriving from the data predecessor, or no change at all.

Any source narrower than the register is widened by sign extension: its top bit is copied into every upper bit. A path that ends at an instruction destination needs no signal bit, so feeding such a path through the narrower slice loses nothing.

A move that keeps the path instead samples one bit of the instruction into a one-bit flush register. The attached ship reads that bit when deciding whether to fire. A move is taken only when its strobe is high and its predicate allows execution.

Top module: `dock_path_latch`

## Requirements
- R1: While `rst_n` is low, `path_q` and `flush_q` are both zero.
- R2: On a taken move with `src_sel` = 2'b01, `path_q` becomes the 13-bit `imm_path`, sign-extended to `PATH_W` bits, on the next clock edge.
- R3: On a taken move with `src_sel` = 2'b10, `path_q` becomes bits 37 down to 26 of `dp_word`, sign-extended to `PATH_W` bits, on the next clock edge.
- R4: On a taken move with `src_sel` = 2'b00, `path_q` keeps its value and `flush_q` takes the value of `flush_bit`.
- R5: On a taken move with `src_sel` = 2'b01 or 2'b10, `flush_q` keeps its value.
- R6: A move is taken only when `mv_go` and `pred_ok` are both high. Otherwise neither output changes.
- R7: The reserved code `src_sel` = 2'b11 changes neither output, even when the move is taken.
- R8: Sign extension fills all upper bits with ones when the source's top bit is 1, and with zeros when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mv_go | input | 1 | Decoded move strobe |
| pred_ok | input | 1 | Predicate allows execution |
| src_sel | input | 2 | Path source: 00 keep, 01 immediate, 10 data slice, 11 reserved |
| imm_path | input | 13 | Immediate path field |
| dp_word | input | DP_W (38) | Word from the data predecessor |
| flush_bit | input | 1 | Flush indicator bit of the move |
| path_q | output | PATH_W (16) | Current outgoing path |
| flush_q | output | 1 | Flush register for the ship |

## Verification
Two functions can meet in a single cycle: the path-load or flush-capture decision, and the predicate veto. When they meet, the veto must win.

The bench provokes this case by raising `mv_go` with every source code while `pred_ok` is low. It also drives inputs that differ from the held state, including a `flush_bit` opposite to the stored flag and a negative immediate. It then checks that both outputs are unchanged on the next edge.

Hold moves are also issued back to back with loads. This shows that the flush flag moves only on keep moves, and that the path moves only on loads.

// File: rtl/dock_path_latch.sv
module dock_path_latch #(
  parameter int PATH_W = 16,
  parameter int IMM_W  = 13,
  parameter int DP_W   = 38,
  parameter int FLD_HI = 37,
  parameter int FLD_LO = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_go,
  input  logic              pred_ok,
  input  logic [1:0]        src_sel,
  input  logic [IMM_W-1:0]  imm_path,
  input  logic [DP_W-1:0]   dp_word,
  input  logic              flush_bit,
  output logic [PATH_W-1:0] path_q,
  output logic              flush_q
);
  localparam int FLD_W = FLD_HI - FLD_LO + 1;
  localparam logic [1:0] SEL_KEEP = 2'b00;
  localparam logic [1:0] SEL_IMM  = 2'b01;
  localparam logic [1:0] SEL_DATA = 2'b10;

  logic              take;
  logic [FLD_W-1:0]  dp_fld;
  logic [PATH_W-1:0] imm_ext, dp_ext;

  assign take    = mv_go & pred_ok;
  assign dp_fld  = dp_word[FLD_HI:FLD_LO];
  assign imm_ext = {{(PATH_W-IMM_W){imm_path[IMM_W-1]}}, imm_path};
  assign dp_ext  = {{(PATH_W-FLD_W){dp_fld[FLD_W-1]}}, dp_fld};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_q  <= '0;
      flush_q <= 1'b0;
    end else if (take) begin
      case (src_sel)
        SEL_IMM:  path_q  <= imm_ext;
        SEL_DATA: path_q  <= dp_ext;
        SEL_KEEP: flush_q <= flush_bit;
        default:  ;
      endcase
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mv_go && pred_ok) |=> $stable(path_q) && $stable(flush_q)); // R6
  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_go && pred_ok && src_sel == 2'b01) |=>
      path_q == {{(PATH_W-IMM_W){$past(imm_path[IMM_W-1])}}, $past(imm_path)}); // R2
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_go && pred_ok && src_sel == 2'b10) |=>
      path_q[FLD_W-1:0] == $past(dp_word[FLD_HI:FLD_LO])
      && (path_q[PATH_W-1:FLD_W] == '0 || path_q[PATH_W-1:FLD_W] == '1)); // R3
  AST_KEEP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_go && pred_ok && src_sel == 2'b00) |=>
      $stable(path_q) && flush_q == $past(flush_bit)); // R4
  AST_LOAD_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_go && pred_ok && (src_sel == 2'b01 || src_sel == 2'b10)) |=> $stable(flush_q)); // R5
  AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_go && pred_ok && src_sel == 2'b11) |=> $stable(path_q) && $stable(flush_q)); // R7
endmodule

// File: tb/test_dock_path_latch.sv
`timescale 1ns/1ps
module test_dock_path_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mv_go = 1'b0, pred_ok = 1'b0, flush_bit = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic [12:0] imm_path = '0;
  logic [37:0] dp_word = '0;
  logic [15:0] path_q;
  logic        flush_q;
  int n_chk = 0, n_bad = 0;
  logic [15:0] e_path = '0;
  logic        e_flush = 1'b0;

  always #2.5 clk = ~clk;

  dock_path_latch i_dock_path_latch (
    .clk(clk), .rst_n(rst_n), .mv_go(mv_go), .pred_ok(pred_ok),
    .src_sel(src_sel), .imm_path(imm_path), .dp_word(dp_word),
    .flush_bit(flush_bit), .path_q(path_q), .flush_q(flush_q));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic move(input logic go, input logic ok, input logic [1:0] sel,
                      input logic [12:0] im, input logic [37:0] dp, input logic fl);
    @(negedge clk);
    mv_go = go; pred_ok = ok; src_sel = sel; imm_path = im; dp_word = dp; flush_bit = fl;
    @(posedge clk); #1;
    mv_go = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 path", path_q, 16'h0);
    check("R1 flush", {15'b0, flush_q}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 path after release", path_q, 16'h0);
  endtask

  task automatic t_imm;
    move(1, 1, 2'b01, 13'h0ABC, '0, 1'b1);
    e_path = 16'h0ABC;
    check("R2 positive imm", path_q, e_path);
    check("R5 flush held on imm", {15'b0, flush_q}, {15'b0, e_flush});
    move(1, 1, 2'b01, 13'h1234, '0, 1'b1);
    e_path = 16'hF234;
    check("R8 negative imm extension", path_q, e_path);
  endtask

  task automatic t_data;
    move(1, 1, 2'b10, 13'h0, {12'h5A5, 26'h3FFFFFF}, 1'b1);
    e_path = 16'h05A5;
    check("R3 positive data slice", path_q, e_path);
    move(1, 1, 2'b10, 13'h0, {12'h801, 26'h0}, 1'b1);
    e_path = 16'hF801;
    check("R8 negative data slice", path_q, e_path);
    check("R5 flush held on data", {15'b0, flush_q}, {15'b0, e_flush});
  endtask

  task automatic t_keep;
    move(1, 1, 2'b00, 13'h0555, {12'h123, 26'h0}, 1'b1);
    e_flush = 1'b1;
    check("R4 path kept", path_q, e_path);
    check("R4 flush captured 1", {15'b0, flush_q}, 16'h1);
    move(1, 1, 2'b01, 13'h0011, '0, 1'b0);
    e_path = 16'h0011;
    check("R5 flush survives load", {15'b0, flush_q}, 16'h1);
    move(1, 1, 2'b00, 13'h1FFF, '0, 1'b0);
    e_flush = 1'b0;
    check("R4 flush captured 0", {15'b0, flush_q}, 16'h0);
    check("R4 path kept again", path_q, e_path);
  endtask

  task automatic t_veto;
    for (int s = 0; s < 4; s++) begin
      move(1, 0, s[1:0], 13'h1F00, {12'hFFF, 26'h0}, ~e_flush);
      check("R6 predicate veto path", path_q, e_path);
      check("R6 predicate veto flush", {15'b0, flush_q}, {15'b0, e_flush});
    end
    move(0, 1, 2'b01, 13'h1F00, '0, 1'b1);
    check("R6 no strobe", path_q, e_path);
  endtask

  task automatic t_rsvd;
    move(1, 1, 2'b11, 13'h1AAA, {12'hAAA, 26'h0}, ~e_flush);
    check("R7 reserved path", path_q, e_path);
    check("R7 reserved flush", {15'b0, flush_q}, {15'b0, e_flush});
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    t_reset;
    t_imm;
    t_data;
    t_keep;
    t_veto;
    t_rsvd;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule